// File: doc/BRIEF.md
# Display Core Clock Retune Sequencer

This block moves the display core clock from its present rate to a requested rate in kHz. It accepts one request at a time. A request that is not one of the six supported rates is refused at once, and nothing else changes. For a supported rate the block does the following, in order:

- It warns the power controller through a mailbox port. If the power controller refuses, the block stops.
- It turns the PLL off and waits for lock to drop, but only for the transitions that need it.
- It sets the PLL multiplier, turns the PLL on and waits for lock.
- It writes the post-divider select, the precharge bit and a fixed-point rate field into a control word.
- It tells the power controller the new rate.

The stored current rate is updated only when the power controller accepts this last message.

The 19.2 MHz rate is a bypass rate. It leaves the PLL off and skips the multiplier and control word. The output rate is 19.2 MHz × multiplier / 2 / divider. The analog PLL is outside the block. Its lock indication comes in on an asynchronous pin, which the block synchronizes. A lock or unlock wait that runs past its limit sets a flag, and the sequence carries on.

Requests use a valid/ready handshake. A request is taken only while `req_ready` is high, and `req_ready` stays low from acceptance until the completion has been taken. A completion stays on `done_valid`/`done_status` until `done_ready` is seen. The mailbox request port is valid/ready. Once raised, `mb_req_valid`, `mb_cmd` and `mb_data` hold until `mb_req_ready` is high on a clock edge. The mailbox answers each accepted request with a one-cycle `mb_rsp_valid` pulse that carries `mb_rsp_err`.

Top module: `cclk_retune_seq`

## Requirements
- R1: After reset `cur_khz` is 19200, `pll_en` is 0, `pll_ratio` is 0, `ctl_word` is 0, `lock_err` is 0, `req_ready` is 1, and `mb_req_valid` and `done_valid` are 0.
- R2: A target outside {19200, 144000, 288000, 384000, 576000, 624000} completes with `done_status` 1 (rejected). It sends no mailbox request and leaves `pll_en`, `pll_ratio`, `ctl_word` and `cur_khz` unchanged.
- R3: The first mailbox request for a supported target carries command 0x17 and data 0x80000000. If its response has `mb_rsp_err` set, the request completes with status 2, and PLL, control word and current rate are untouched.
- R4: The PLL is turned off, and the block waits for lock to clear, exactly when the target is 19200 or 624000, or when the rate read back from `ctl_word[10:0]` × 500 + 1000 equals 624000. In all other cases `pll_en` never falls. `pll_ratio` changes only in the cycle in which `pll_en` rises.
- R5: For a target other than 19200, `pll_ratio` becomes 65 for 624000 and 60 for the others. `pll_en` ends at 1, and the control word is written only after the lock wait.
- R6: `ctl_word[23:22]` selects the divider: 0 = ÷1 (576000, 624000), 1 = ÷1.5 (384000), 2 = ÷2 (288000), 3 = ÷4 (144000).
- R7: `ctl_word[16]` is 1 when the target is 500000 kHz or more, and 0 otherwise.
- R8: `ctl_word[10:0]` equals (target − 1000) / 500, rounded down. All other bits of `ctl_word` are 0.
- R9: The final mailbox request carries command 0x17 and data ceil(target / 25000). On success `cur_khz` becomes the target and the status is 0. On error the status is 2 and `cur_khz` keeps its old value.
- R10: When a lock or unlock wait exceeds `LOCK_TMO` cycles, `lock_err` is set and the sequence still finishes. `lock_err` clears when the next request is accepted.
- R11: Target 19200 leaves `pll_en` at 0, with `pll_ratio` and `ctl_word` unchanged.
- R12: `req_ready` is low while a request is in flight. `done_valid`/`done_status` hold until `done_ready`. `mb_req_valid`, `mb_cmd` and `mb_data` hold until `mb_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Rate request valid |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_khz | input | 20 | Requested rate in kHz |
| done_valid | output | 1 | Completion available |
| done_ready | input | 1 | Completion taken |
| done_status | output | 2 | 0 ok, 1 rejected, 2 mailbox error |
| mb_req_valid | output | 1 | Mailbox request valid |
| mb_req_ready | input | 1 | Mailbox request accepted |
| mb_cmd | output | 8 | Mailbox command |
| mb_data | output | 32 | Mailbox payload |
| mb_rsp_valid | input | 1 | Mailbox response pulse |
| mb_rsp_err | input | 1 | Mailbox response error |
| pll_en | output | 1 | PLL enable |
| pll_lock | input | 1 | PLL lock, asynchronous |
| pll_ratio | output | 8 | PLL multiplier |
| ctl_word | output | 32 | Clock control register image |
| cur_khz | output | 20 | Stored current rate in kHz |
| lock_err | output | 1 | A lock or unlock wait expired |

## Verification
Directed transitions cover the cases the PLL decision has to tell apart:
- first enable from reset;
- leaving 624000, which forces an off/on toggle, against moving between ratio-60 rates, which must not toggle;
- entering and leaving bypass.

The 384000 and 576000 targets sit on either side of the precharge threshold. An arbitrary illegal value checks that a refused request has no side effects. Injected refusals on the first and on the last mailbox message separate an aborted sequence from a completed hardware change whose rate is not recorded. A PLL whose lock never arrives exercises the report-and-continue timeout. A seeded random run then mixes legal and illegal targets, mailbox errors and a stuck lock, with back-pressure on every handshake.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_REJECT   = 2'd1,
    ST_MBOX_ERR = 2'd2
  } cclk_status_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_NOTIFY, S_NOTIFY_RSP, S_PLL_OFF, S_UNLOCK,
    S_PLL_ON, S_LOCK, S_PROG, S_REPORT, S_REPORT_RSP, S_DONE
  } cclk_state_e;

  localparam logic [1:0] DIV_1   = 2'd0;
  localparam logic [1:0] DIV_1P5 = 2'd1;
  localparam logic [1:0] DIV_2   = 2'd2;
  localparam logic [1:0] DIV_4   = 2'd3;

  localparam int DIV_LSB   = 22;
  localparam int PRE_BIT   = 16;
  localparam int FIELD_W   = 11;
endpackage

// File: rtl/cclk_decode.sv
module cclk_decode
  import cclk_pkg::*;
#(
  parameter int KHZ_W         = 20,
  parameter int BYPASS_KHZ    = 19200,
  parameter int FAST_KHZ      = 624000,
  parameter int PRECHARGE_KHZ = 500000,
  parameter int FIELD_OFS_KHZ = 1000,
  parameter int FIELD_LSB_KHZ = 500,
  parameter int MB_UNIT_KHZ   = 25000
) (
  input  logic [KHZ_W-1:0]   khz,
  output logic               ok,
  output logic               bypass,
  output logic [7:0]         ratio,
  output logic [1:0]         div_sel,
  output logic               precharge,
  output logic [FIELD_W-1:0] field,
  output logic [31:0]        mb_rate
);
  localparam int NRATES = 5;
  localparam int RATE_KHZ [NRATES] = '{144000, 288000, 384000, 576000, FAST_KHZ};
  localparam logic [1:0] RATE_DIV [NRATES] = '{DIV_4, DIV_2, DIV_1P5, DIV_1, DIV_1};
  localparam logic [7:0] RATE_MUL [NRATES] = '{8'd60, 8'd60, 8'd60, 8'd60, 8'd65};

  logic [NRATES-1:0] hit;
  logic [31:0]       k32;

  assign k32 = 32'(khz);

  for (genvar i = 0; i < NRATES; i++) begin : g_match
    assign hit[i] = (k32 == 32'(RATE_KHZ[i]));
  end

  always_comb begin
    ratio   = '0;
    div_sel = '0;
    for (int i = 0; i < NRATES; i++) begin
      if (hit[i]) begin
        ratio   = RATE_MUL[i];
        div_sel = RATE_DIV[i];
      end
    end
  end

  assign bypass    = (k32 == 32'(BYPASS_KHZ));
  assign ok        = bypass || (|hit);
  assign precharge = (k32 >= 32'(PRECHARGE_KHZ));
  assign field     = FIELD_W'((k32 - 32'(FIELD_OFS_KHZ)) / 32'(FIELD_LSB_KHZ));
  assign mb_rate   = (k32 + 32'(MB_UNIT_KHZ - 1)) / 32'(MB_UNIT_KHZ);
endmodule

// File: rtl/cclk_lock_wait.sv
module cclk_lock_wait #(
  parameter int LOCK_TMO = 20000,
  parameter int SYNC_N   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic want,
  input  logic lock_async,
  output logic met,
  output logic expired
);
  localparam int CNT_W = $clog2(LOCK_TMO + 1);

  logic [SYNC_N-1:0] sync_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-2:0], lock_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end

  assign met     = run && (sync_q[SYNC_N-1] == want);
  assign expired = (cnt_q == CNT_W'(LOCK_TMO));
endmodule

// File: rtl/cclk_retune_seq.sv
module cclk_retune_seq
  import cclk_pkg::*;
#(
  parameter int          KHZ_W       = 20,
  parameter int          RESET_KHZ   = 19200,
  parameter int          FAST_KHZ    = 624000,
  parameter int          LOCK_TMO    = 20000,
  parameter logic [7:0]  MB_FREQ_CMD = 8'h17,
  parameter logic [31:0] MB_WARN     = 32'h8000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [KHZ_W-1:0] req_khz,
  output logic             done_valid,
  input  logic             done_ready,
  output logic [1:0]       done_status,
  output logic             mb_req_valid,
  input  logic             mb_req_ready,
  output logic [7:0]       mb_cmd,
  output logic [31:0]      mb_data,
  input  logic             mb_rsp_valid,
  input  logic             mb_rsp_err,
  output logic             pll_en,
  input  logic             pll_lock,
  output logic [7:0]       pll_ratio,
  output logic [31:0]      ctl_word,
  output logic [KHZ_W-1:0] cur_khz,
  output logic             lock_err
);
  localparam int FAST_FIELD = (FAST_KHZ - 1000) / 500;

  cclk_state_e        state_q;
  logic [KHZ_W-1:0]   tgt_q;
  cclk_status_e       status_q;

  logic               d_ok, d_bypass, d_pre;
  logic [7:0]         d_ratio;
  logic [1:0]         d_div;
  logic [FIELD_W-1:0] d_field;
  logic [31:0]        d_mb_rate;
  logic               w_run, w_want, w_met, w_exp;
  logic               need_toggle;

  cclk_decode #(.KHZ_W(KHZ_W), .BYPASS_KHZ(RESET_KHZ), .FAST_KHZ(FAST_KHZ)) u_dec (
    .khz(tgt_q), .ok(d_ok), .bypass(d_bypass), .ratio(d_ratio),
    .div_sel(d_div), .precharge(d_pre), .field(d_field), .mb_rate(d_mb_rate)
  );

  cclk_lock_wait #(.LOCK_TMO(LOCK_TMO)) u_wait (
    .clk(clk), .rst_n(rst_n), .run(w_run), .want(w_want),
    .lock_async(pll_lock), .met(w_met), .expired(w_exp)
  );

  assign w_run  = (state_q == S_UNLOCK) || (state_q == S_LOCK);
  assign w_want = (state_q == S_LOCK);

  // the current rate is read back from the control word field
  assign need_toggle = d_bypass || (32'(tgt_q) == 32'(FAST_KHZ)) ||
                       (ctl_word[FIELD_W-1:0] == FIELD_W'(FAST_FIELD));

  assign req_ready    = (state_q == S_IDLE);
  assign done_valid   = (state_q == S_DONE);
  assign done_status  = status_q;
  assign mb_req_valid = (state_q == S_NOTIFY) || (state_q == S_REPORT);
  assign mb_cmd       = mb_req_valid ? MB_FREQ_CMD : 8'h00;
  assign mb_data      = (state_q == S_NOTIFY) ? MB_WARN :
                        (state_q == S_REPORT) ? d_mb_rate : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      tgt_q     <= '0;
      status_q  <= ST_OK;
      pll_en    <= 1'b0;
      pll_ratio <= '0;
      ctl_word  <= '0;
      cur_khz   <= KHZ_W'(RESET_KHZ);
      lock_err  <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          tgt_q    <= req_khz;
          lock_err <= 1'b0;
          state_q  <= S_CHECK;
        end
        S_CHECK: begin
          if (d_ok) state_q <= S_NOTIFY;
          else begin
            status_q <= ST_REJECT;
            state_q  <= S_DONE;
          end
        end
        S_NOTIFY: if (mb_req_ready) state_q <= S_NOTIFY_RSP;
        S_NOTIFY_RSP: if (mb_rsp_valid) begin
          if (mb_rsp_err) begin
            status_q <= ST_MBOX_ERR;
            state_q  <= S_DONE;
          end else if (need_toggle) state_q <= S_PLL_OFF;
          else                      state_q <= S_PLL_ON;
        end
        S_PLL_OFF: begin
          pll_en  <= 1'b0;
          state_q <= S_UNLOCK;
        end
        S_UNLOCK: if (w_met || w_exp) begin
          if (!w_met) lock_err <= 1'b1;
          state_q <= d_bypass ? S_REPORT : S_PLL_ON;
        end
        S_PLL_ON: begin
          pll_ratio <= d_ratio;
          pll_en    <= 1'b1;
          state_q   <= S_LOCK;
        end
        S_LOCK: if (w_met || w_exp) begin
          if (!w_met) lock_err <= 1'b1;
          state_q <= S_PROG;
        end
        S_PROG: begin
          ctl_word                      <= '0;
          ctl_word[DIV_LSB+1:DIV_LSB]   <= d_div;
          ctl_word[PRE_BIT]             <= d_pre;
          ctl_word[FIELD_W-1:0]         <= d_field;
          state_q                       <= S_REPORT;
        end
        S_REPORT: if (mb_req_ready) state_q <= S_REPORT_RSP;
        S_REPORT_RSP: if (mb_rsp_valid) begin
          if (mb_rsp_err) status_q <= ST_MBOX_ERR;
          else begin
            status_q <= ST_OK;
            cur_khz  <= tgt_q;
          end
          state_q <= S_DONE;
        end
        S_DONE: if (done_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cclk_retune_seq_chk.sv
module cclk_retune_seq_chk #(
  parameter int KHZ_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             done_valid,
  input logic             done_ready,
  input logic [1:0]       done_status,
  input logic             mb_req_valid,
  input logic             mb_req_ready,
  input logic [7:0]       mb_cmd,
  input logic [31:0]      mb_data,
  input logic             pll_en,
  input logic [7:0]       pll_ratio,
  input logic [31:0]      ctl_word,
  input logic [KHZ_W-1:0] cur_khz
);
  a_r12_mb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req_valid && !mb_req_ready |=> mb_req_valid && $stable(mb_cmd) && $stable(mb_data));

  a_r12_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_ready |=> done_valid && $stable(done_status));

  a_r12_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !req_ready);

  a_r3_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req_valid |-> mb_cmd == 8'h17);

  a_r9_cur_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_khz) |-> done_valid && done_status == 2'd0);

  a_r4_ratio_with_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_ratio) |-> $rose(pll_en));

  a_r5_ctl_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_word) |-> pll_en);
endmodule

bind cclk_retune_seq cclk_retune_seq_chk #(.KHZ_W(KHZ_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done_valid(done_valid),
  .done_ready(done_ready), .done_status(done_status), .mb_req_valid(mb_req_valid),
  .mb_req_ready(mb_req_ready), .mb_cmd(mb_cmd), .mb_data(mb_data), .pll_en(pll_en),
  .pll_ratio(pll_ratio), .ctl_word(ctl_word), .cur_khz(cur_khz)
);

// File: tb/cclk_retune_seq_tb_top.sv
module cclk_retune_seq_tb_top;
  localparam int TMO = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_khz = '0;
  logic        done_ready = 1'b0;
  logic        mb_req_ready = 1'b0;
  logic        mb_rsp_valid = 1'b0;
  logic        mb_rsp_err = 1'b0;
  logic        pll_lock = 1'b0;
  logic        req_ready, done_valid, mb_req_valid, pll_en, lock_err;
  logic [1:0]  done_status;
  logic [7:0]  mb_cmd, pll_ratio;
  logic [31:0] mb_data, ctl_word;
  logic [19:0] cur_khz;

  int checks = 0;
  int errors = 0;
  bit nerr = 0, rerr = 0, stuck = 0;
  int mb_cnt = 0;
  logic [31:0] log_data [256];
  logic [7:0]  log_cmd [256];
  int falls = 0;
  logic pll_prev = 1'b0;
  int pll_cnt = 0;

  logic [19:0] e_cur = 20'd19200;
  logic [31:0] e_ctl = '0;
  logic [7:0]  e_ratio = '0;
  logic        e_en = 1'b0;

  always #5 clk = ~clk;

  cclk_retune_seq #(.LOCK_TMO(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_khz(req_khz), .done_valid(done_valid), .done_ready(done_ready),
    .done_status(done_status), .mb_req_valid(mb_req_valid), .mb_req_ready(mb_req_ready),
    .mb_cmd(mb_cmd), .mb_data(mb_data), .mb_rsp_valid(mb_rsp_valid),
    .mb_rsp_err(mb_rsp_err), .pll_en(pll_en), .pll_lock(pll_lock),
    .pll_ratio(pll_ratio), .ctl_word(ctl_word), .cur_khz(cur_khz), .lock_err(lock_err)
  );

  // PLL model: lock follows enable after five cycles unless stuck low
  always @(posedge clk) begin
    if (stuck) begin
      pll_lock <= 1'b0;
      pll_cnt  <= 0;
    end else if (pll_en != pll_lock) begin
      pll_cnt <= pll_cnt + 1;
      if (pll_cnt == 4) begin
        pll_lock <= pll_en;
        pll_cnt  <= 0;
      end
    end else pll_cnt <= 0;
  end

  always @(posedge clk) begin
    pll_prev <= pll_en;
    if (pll_prev && !pll_en) falls <= falls + 1;
  end

  // mailbox responder with random back-pressure and latency
  initial begin
    forever begin
      @(negedge clk);
      if (mb_req_valid) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        log_data[mb_cnt % 256] = mb_data;
        log_cmd[mb_cnt % 256]  = mb_cmd;
        mb_req_ready = 1'b1;
        @(negedge clk);
        mb_req_ready = 1'b0;
        repeat ($urandom_range(1, 3)) @(negedge clk);
        mb_rsp_err = (log_data[mb_cnt % 256] == 32'h8000_0000) ? nerr : rerr;
        mb_rsp_valid = 1'b1;
        mb_cnt = mb_cnt + 1;
        @(negedge clk);
        mb_rsp_valid = 1'b0;
        mb_rsp_err = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit legal(input int k);
    return k == 19200 || k == 144000 || k == 288000 || k == 384000 ||
           k == 576000 || k == 624000;
  endfunction

  function automatic logic [1:0] div_of(input int k);
    case (k)
      144000:  return 2'd3;
      288000:  return 2'd2;
      384000:  return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  task automatic run_req(input int k, input bit ne, input bit re, input bit st);
    int c0, f0;
    bit tog, byp;
    logic [31:0] w;
    @(negedge clk);
    c0 = mb_cnt; f0 = falls;
    nerr = ne; rerr = re; stuck = st;
    req_khz = 20'(k); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 busy req_ready", 32'(req_ready), 0);
    while (!done_valid) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R12 done held", 32'(done_valid), 1);
    byp = (k == 19200);
    tog = byp || k == 624000 || (int'(e_ctl[10:0]) * 500 + 1000 == 624000);
    if (!legal(k)) begin
      chk("R2 status", 32'(done_status), 1);
      chk("R2 no mailbox", 32'(mb_cnt - c0), 0);
    end else begin
      chk("R3 first cmd", 32'(log_cmd[c0 % 256]), 32'h17);
      chk("R3 first data", log_data[c0 % 256], 32'h8000_0000);
      if (ne) begin
        chk("R3 abort status", 32'(done_status), 2);
        chk("R3 abort mailbox count", 32'(mb_cnt - c0), 1);
      end else begin
        chk("R4 pll falls", 32'(falls - f0), 32'(tog && e_en));
        if (byp) e_en = 1'b0;
        else begin
          e_en = 1'b1;
          e_ratio = (k == 624000) ? 8'd65 : 8'd60;
          w = '0;
          w[23:22] = div_of(k);
          w[16] = (k >= 500000);
          w[10:0] = 11'((k - 1000) / 500);
          e_ctl = w;
        end
        chk("R10 lock_err", 32'(lock_err), 32'(st && !byp));
        chk("R9 report cmd", 32'(log_cmd[(c0 + 1) % 256]), 32'h17);
        chk("R9 report data", log_data[(c0 + 1) % 256], 32'((k + 24999) / 25000));
        chk("R9 status", 32'(done_status), re ? 2 : 0);
        if (!re) e_cur = 20'(k);
      end
    end
    chk("R5 R11 pll_en", 32'(pll_en), 32'(e_en));
    chk("R5 R11 pll_ratio", 32'(pll_ratio), 32'(e_ratio));
    chk("R6 R7 R8 ctl_word", ctl_word, e_ctl);
    chk("R9 cur_khz", 32'(cur_khz), 32'(e_cur));
    done_ready = 1'b1;
    @(negedge clk);
    done_ready = 1'b0;
    stuck = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int list [6] = '{19200, 144000, 288000, 384000, 576000, 624000};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cur_khz", 32'(cur_khz), 19200);
    chk("R1 pll_en", 32'(pll_en), 0);
    chk("R1 ctl_word", ctl_word, 0);
    chk("R1 ratio", 32'(pll_ratio), 0);
    chk("R1 ready", 32'(req_ready), 1);
    chk("R1 idle ports", 32'({mb_req_valid, done_valid, lock_err}), 0);
    run_req(624000, 0, 0, 0);   // R5 first enable
    run_req(576000, 0, 0, 0);   // R4 leaving 624000 toggles
    run_req(288000, 0, 0, 0);   // R4 no toggle
    run_req(384000, 0, 0, 0);   // R7 below threshold
    run_req(144000, 0, 0, 0);   // R6 divide by 4
    run_req(100000, 0, 0, 0);   // R2 illegal
    run_req(576000, 1, 0, 0);   // R3 notify refused
    run_req(624000, 0, 1, 0);   // R9 report refused
    run_req(19200, 0, 0, 0);    // R11 bypass
    run_req(288000, 0, 0, 1);   // R10 lock never comes
    run_req(576000, 0, 0, 0);
    for (int i = 0; i < 40; i++) begin
      int k;
      int pick = $urandom_range(0, 9);
      k = (pick < 8) ? list[$urandom_range(0, 5)] : int'($urandom_range(0, 700000));
      run_req(k, $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
              $urandom_range(0, 14) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule